// File: doc/BRIEF.md
# Triangle-Wave Spread-Spectrum Dither Generator

This block takes the 10-bit frequency-control code that sets a programmable oscillator. While spreading is enabled, it pulls that code down by a triangle-shaped amount. The deviation is only ever downward: the programmed code is the ceiling, and the sweep travels between zero offset and a peak offset. The peak is a fixed percentage of the programmed code, picked by one select bit, and the result is fed to a downstream DAC-controlled or numerically controlled oscillator model.

A rate tick moves a sweep phase counter one step. A full triangle (ramp up, then ramp down) takes 4096 ticks, so a tick at the master clock rate gives a sweep rate of the master clock divided by 4096. A new base code or a new depth setting is taken only where the triangle crosses zero offset, or while spreading is off, so a reprogramming never makes the output code jump in the middle of a ramp. Dropping the enable clears the sweep phase, so the next enable starts again from zero offset.

Top module: `spread_dither`

## Requirements
- R1: While spreading is enabled, the output code never exceeds the base code held for the current sweep, so the deviation is downward only.
- R2: The peak offset is floor(base × 2 / 100) when `depthSel` is 1 and floor(base × 4 / 100) when `depthSel` is 0. It is reached at sweep phase 2048.
- R3: While `spreadEn` is 0, the output one clock later equals `baseCode` at that edge.
- R4: With sweep phase p in 0..4095, the fold position is t = p for p ≤ 2048 and t = 4096 − p otherwise. The output is base − floor(peak × t / 2048), registered one clock after the phase it uses.
- R5: The phase advances by one, wrapping 4095 to 0, on each clock edge where `spreadEn` and `rateTick` are both 1. It holds otherwise, so one triangle lasts 4096 ticks.
- R6: An edge with `spreadEn` at 0 clears the phase to 0, so re-enabling starts at zero offset.
- R7: A change of `baseCode` or `depthSel` during a sweep has no effect on the output until the phase returns to 0. At phase 0 the new values take effect at once, with zero offset.
- R8: During reset the output code is 0 and the phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baseCode | input | 10 | Programmed (undithered) frequency code |
| depthSel | input | 1 | Depth select: 1 = 2 % peak, 0 = 4 % peak |
| spreadEn | input | 1 | Spread enable; low passes the base code through |
| rateTick | input | 1 | Sweep advance strobe |
| ditherCode | output | 10 | Dithered frequency code |

## Verification
The hardest situation to reach from the ports is a reprogramming in mid-ramp that must stay invisible until the triangle returns to zero, thousands of ticks later. The stimulus runs a sweep to its midpoint and changes both the base code and the depth there. It checks that the output still follows the old setting, then runs on through the wrap and checks that the new setting is picked up at phase 0. It also checks the exact offset a quarter period into the new sweep. Folding at the peak and the wrap at 4095 are covered by a full-period sweep compared cycle by cycle against the closed-form triangle.

// File: rtl/dither_pkg.sv
package dither_pkg;
  // Strobes handed from the sweep control to the datapath
  typedef struct packed {
    logic loadCfg;  // capture base/depth this cycle (zero crossing or disabled)
    logic active;   // spreading is on
  } ditherStrobe_t;
endpackage

// File: rtl/dither_ctrl.sv
module dither_ctrl
  import dither_pkg::*;
#(
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spreadEn,
  input  logic               rateTick,
  output logic [PHASE_W-1:0] phase,
  output logic [PHASE_W-1:0] triPos,
  output ditherStrobe_t      strobes
);
  localparam logic [PHASE_W-1:0] PHASE_ZERO = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PHASE_ZERO;
    end else if (!spreadEn) begin
      phase <= PHASE_ZERO;
    end else if (rateTick) begin
      phase <= phase + 1'b1;
    end
  end

  // Fold: second half of the period mirrors back down (modular negate)
  always_comb begin
    if (phase[PHASE_W-1]) begin
      triPos = PHASE_ZERO - phase;
    end else begin
      triPos = phase;
    end
  end

  always_comb begin
    strobes.active  = spreadEn;
    strobes.loadCfg = !spreadEn || (phase == PHASE_ZERO);
  end
endmodule

// File: rtl/dither_path.sv
module dither_path
  import dither_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int PHASE_W     = 12,
  parameter int SHALLOW_PCT = 2,
  parameter int DEEP_PCT    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  baseCode,
  input  logic               depthSel,
  input  logic [PHASE_W-1:0] triPos,
  input  ditherStrobe_t      strobes,
  output logic [CODE_W-1:0]  ditherCode,
  output logic [CODE_W-1:0]  heldBase
);
  localparam int PCT_W   = 7;
  localparam int PROD_W  = CODE_W + PCT_W;
  localparam int SPAN_W  = CODE_W + PHASE_W;
  localparam int SHIFT   = PHASE_W - 1;
  localparam logic [PCT_W-1:0]  PCT_LO  = PCT_W'(SHALLOW_PCT);
  localparam logic [PCT_W-1:0]  PCT_HI  = PCT_W'(DEEP_PCT);
  localparam logic [PROD_W-1:0] HUNDRED = PROD_W'(100);

  logic              heldDepth;
  logic [CODE_W-1:0] effBase;
  logic              effDepth;
  logic [PCT_W-1:0]  pct;
  logic [PROD_W-1:0] scaled;
  logic [PROD_W-1:0] peakWide;
  logic [CODE_W-1:0] peak;
  logic [SPAN_W-1:0] span;
  logic [SPAN_W-1:0] spanShift;
  logic [CODE_W-1:0] offset;
  logic [CODE_W-1:0] nextCode;

  // Configuration in force for this cycle
  always_comb begin
    effBase  = strobes.loadCfg ? baseCode : heldBase;
    effDepth = strobes.loadCfg ? depthSel : heldDepth;
    pct      = effDepth ? PCT_LO : PCT_HI;
  end

  // Peak = base * pct / 100, truncated
  always_comb begin
    scaled   = PROD_W'(effBase) * PROD_W'(pct);
    peakWide = scaled / HUNDRED;
    peak     = CODE_W'(peakWide);
  end

  // Offset = peak * fold / half-period, then one-sided subtraction
  always_comb begin
    span      = SPAN_W'(peak) * SPAN_W'(triPos);
    spanShift = span >> SHIFT;
    offset    = CODE_W'(spanShift);
    nextCode  = strobes.active ? (effBase - offset) : baseCode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      heldBase   <= '0;
      heldDepth  <= 1'b0;
      ditherCode <= '0;
    end else begin
      if (strobes.loadCfg) begin
        heldBase  <= baseCode;
        heldDepth <= depthSel;
      end
      ditherCode <= nextCode;
    end
  end
endmodule

// File: rtl/spread_dither.sv
module spread_dither
  import dither_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int PHASE_W     = 12,
  parameter int SHALLOW_PCT = 2,
  parameter int DEEP_PCT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] baseCode,
  input  logic              depthSel,
  input  logic              spreadEn,
  input  logic              rateTick,
  output logic [CODE_W-1:0] ditherCode
);
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] triPos;
  logic [CODE_W-1:0]  heldBase;
  ditherStrobe_t      strobes;

  dither_ctrl #(.PHASE_W(PHASE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .spreadEn (spreadEn),
    .rateTick (rateTick),
    .phase    (phase),
    .triPos   (triPos),
    .strobes  (strobes)
  );

  dither_path #(
    .CODE_W      (CODE_W),
    .PHASE_W     (PHASE_W),
    .SHALLOW_PCT (SHALLOW_PCT),
    .DEEP_PCT    (DEEP_PCT)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .baseCode   (baseCode),
    .depthSel   (depthSel),
    .triPos     (triPos),
    .strobes    (strobes),
    .ditherCode (ditherCode),
    .heldBase   (heldBase)
  );
endmodule

// File: rtl/spread_dither_chk.sv
module spread_dither_chk
  import dither_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int PHASE_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CODE_W-1:0]  baseCode,
  input logic               spreadEn,
  input logic               rateTick,
  input logic [CODE_W-1:0]  ditherCode,
  input logic [PHASE_W-1:0] phase,
  input logic [CODE_W-1:0]  heldBase,
  input ditherStrobe_t      strobes
);
  logic steady;
  assign steady = spreadEn && !strobes.loadCfg;

  AST_BELOW_HELD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    steady |=> ditherCode <= $past(heldBase)); // R1

  AST_DISABLED_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !spreadEn |=> ditherCode == $past(baseCode)); // R3

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && $past(steady)) |=>
      (ditherCode == $past(ditherCode)) ||
      (ditherCode == $past(ditherCode) + 1'b1) ||
      (ditherCode + 1'b1 == $past(ditherCode))); // R4

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (spreadEn && rateTick) |=> phase == $past(phase) + 1'b1); // R5

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (spreadEn && !rateTick) |=> $stable(phase)); // R5

  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !spreadEn |=> phase == '0); // R6

  AST_ZERO_CROSS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (spreadEn && strobes.loadCfg) |=> ditherCode == $past(baseCode)); // R7
endmodule

bind spread_dither spread_dither_chk #(
  .CODE_W  (CODE_W),
  .PHASE_W (PHASE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baseCode   (baseCode),
  .spreadEn   (spreadEn),
  .rateTick   (rateTick),
  .ditherCode (ditherCode),
  .phase      (phase),
  .heldBase   (heldBase),
  .strobes    (strobes)
);

// File: tb/tb_spread_dither.sv
`timescale 1ns/1ps
module tb_spread_dither;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] baseCode = '0;
  logic       depthSel = 1'b0;
  logic       spreadEn = 1'b0;
  logic       rateTick = 1'b0;
  logic [9:0] ditherCode;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  spread_dither dut (
    .clk(clk), .rst_n(rst_n), .baseCode(baseCode), .depthSel(depthSel),
    .spreadEn(spreadEn), .rateTick(rateTick), .ditherCode(ditherCode)
  );

  typedef struct packed {
    logic [9:0]  base;
    logic        depth;
    logic        spread;
    logic [12:0] edges;
    logic [9:0]  expect_;
  } vec_t;

  // R2 depths, R4 fold, R5 wrap, R3 pass-through
  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{10'd1000, 1'b0, 1'b1, 13'd2049, 10'd960},
    '{10'd1000, 1'b1, 1'b1, 13'd2049, 10'd980},
    '{10'd1000, 1'b0, 1'b1, 13'd1025, 10'd980},
    '{10'd500,  1'b0, 1'b1, 13'd3073, 10'd490},
    '{10'd1023, 1'b1, 1'b1, 13'd2049, 10'd1003},
    '{10'd1023, 1'b0, 1'b1, 13'd2049, 10'd983},
    '{10'd49,   1'b0, 1'b1, 13'd2049, 10'd48},
    '{10'd49,   1'b0, 1'b1, 13'd2048, 10'd49},
    '{10'd0,    1'b0, 1'b1, 13'd2049, 10'd0},
    '{10'd700,  1'b0, 1'b0, 13'd5,    10'd700},
    '{10'd1000, 1'b0, 1'b1, 13'd4097, 10'd1000},
    '{10'd1000, 1'b0, 1'b1, 13'd1,    10'd1000}
  };

  task automatic check(string tag, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int expOut(int base, bit depth, int ph);
    int tpos;
    int peak;
    tpos = (ph <= 2048) ? ph : 4096 - ph;
    peak = (base * (depth ? 2 : 4)) / 100;
    return base - (peak * tpos) / 2048;
  endfunction

  task automatic clearPhase();
    spreadEn = 1'b0;
    rateTick = 1'b1;
    edges(2);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 5.0);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    // R8: reset state
    edges(4);
    check("R8 reset output", ditherCode, 0);
    rst_n = 1'b1;

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      clearPhase();
      baseCode = VECS[v].base;
      depthSel = VECS[v].depth;
      spreadEn = VECS[v].spread;
      rateTick = 1'b1;
      edges(int'(VECS[v].edges));
      check($sformatf("R2/R4/R5 vector %0d", v), ditherCode, int'(VECS[v].expect_));
    end

    // R4, R1: full-period sweep against closed form
    clearPhase();
    baseCode = 10'd1000; depthSel = 1'b0; spreadEn = 1'b1; rateTick = 1'b1;
    for (int k = 1; k <= 4096; k++) begin
      @(negedge clk);
      check($sformatf("R4 sweep edge %0d", k), ditherCode, expOut(1000, 1'b0, k - 1));
      if (ditherCode > 10'd1000) check("R1 above base", ditherCode, 1000);
    end

    // R7: mid-ramp reprogramming deferred to zero crossing
    clearPhase();
    baseCode = 10'd1000; depthSel = 1'b0; spreadEn = 1'b1;
    edges(1025);
    check("R7 before change", ditherCode, 980);
    baseCode = 10'd500; depthSel = 1'b1;
    edges(1);
    check("R7 change ignored mid-ramp", ditherCode, 980);
    edges(3070);
    check("R7 old setting at wrap", ditherCode, 1000);
    edges(1);
    check("R7 new base at crossing", ditherCode, 500);
    edges(1024);
    check("R7 new depth applied", ditherCode, 495);

    // R5: tick gating holds the phase
    clearPhase();
    baseCode = 10'd1000; depthSel = 1'b0; spreadEn = 1'b1;
    edges(100);
    rateTick = 1'b0;
    edges(50);
    check("R5 hold without tick", ditherCode, 999);
    rateTick = 1'b1;
    edges(924);
    check("R5 resume after hold", ditherCode, 981);

    // R3, R6: disable mid-ramp then re-enable
    spreadEn = 1'b0;
    baseCode = 10'd300;
    edges(1);
    check("R3 disabled pass-through", ditherCode, 300);
    baseCode = 10'd1000;
    edges(1);
    check("R3 follows base change", ditherCode, 1000);
    spreadEn = 1'b1;
    edges(2);
    check("R6 restart at zero offset", ditherCode, 1000);
    edges(511);
    check("R6 ramp from zero", ditherCode, 990);

    finishRun();
  end
endmodule